// File: doc/BRIEF.md
# Four-Channel PWM Generator

This block produces four independent pulse-width modulated outputs, each set by a pair of 32-bit cycle counts: a high time and a total period. All counting runs on the bus clock. Software writes the counts through a word-addressed register port. Each channel has one address for its high time and one for its period. Every period starts with the output high, and the output drops once the high-time count has elapsed.

Software writes land in shadow registers. A running channel copies both shadow values into its active pair together, and only when the current period ends. An output period therefore never mixes an old high time with a new period. A channel whose active period is zero is idle. It holds its output low and picks up new shadow values on the very next clock edge, so starting from idle needs no boundary. Writing zero to both registers of a running channel stops it once its current period has finished.

Top module: `pwm_quad_gen`

## Requirements
- R1: Word address 2n selects the high-time register of channel n, and word address 2n+1 selects its period register (byte offsets 8n and 8n+4), for n from 0 to 3. Each register holds a full 32-bit value, and a read returns the shadow contents last written.
- R2: A read from any word address of 8 or above returns zero, and a write to such an address changes no register and no output.
- R3: After reset, every register reads zero and every output is low.
- R4: While a channel runs with active period P and high time H, every P-cycle period shows min(H,P) cycles high followed by the remaining cycles low, repeating without gaps.
- R5: If H is greater than or equal to a nonzero P, the output stays high. If H is zero and P is nonzero, the output stays low.
- R6: A write to a running channel leaves its output unchanged until the current period completes. The next period then uses both shadow values together, starting from its first cycle.
- R7: A channel whose active period is zero is idle: its output is low and its count is zero. A write issued on edge k is in the active registers after edge k+1, and the first period begins in the cycle after edge k+1.
- R8: Writing zero to both registers of a running channel brings its output low and keeps it low once the current period ends.
- R9: The four channels operate independently: writes and periods on one channel never alter the output of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; also the counting clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe; a write is taken when both bus_sel and bus_wr are high |
| bus_wr | input | 1 | Write qualifier |
| bus_waddr | input | 6 | Word address (byte offset divided by four) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_waddr (combinational) |
| pwm_out | output | 4 | One PWM output per channel |

## Verification
A corrupted active register or count shows up as a wrong level on pwm_out. The bench compares every output bit against its model on every cycle, so such a fault is flagged within one period of the channel concerned. An early or late copy from shadow to active registers shifts the start of a period, and the check reports it in the first cycle where the levels differ. A bad decode shows up directly on the read port or as a write landing on the wrong channel's output, and the per-address read-back of all eight registers and the out-of-range accesses reveal it.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

    localparam int unsigned WORD_W = 32;

    typedef logic [WORD_W-1:0] word_t;

    // One channel setting: period count and high-time count.
    typedef struct packed {
        word_t per;
        word_t hi;
    } pwm_cfg_t;

    // Low word-address bit picks the field inside a channel pair.
    typedef enum logic {
        FLD_HIGH   = 1'b0,
        FLD_PERIOD = 1'b1
    } field_e;

    // True on the last cycle of a period, or on every cycle while idle.
    function automatic logic period_end(input pwm_cfg_t c, input word_t cnt);
        return (c.per == '0) || (cnt == c.per - word_t'(1));
    endfunction

    // Output level for a given position within the period.
    function automatic logic out_level(input pwm_cfg_t c, input word_t cnt);
        return (c.per != '0) && (cnt < c.hi);
    endfunction

endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
    import pwm_quad_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_sel,
    input  logic                   bus_wr,
    input  logic [ADDR_W-1:0]      bus_waddr,
    input  word_t                  bus_wdata,
    output word_t                  bus_rdata,
    output pwm_cfg_t [NUM_CH-1:0]  shadow_o
);

    localparam int unsigned IDX_W = ADDR_W - 1;
    localparam int unsigned SPAN  = 2 * NUM_CH;

    logic [IDX_W-1:0]      idx;
    field_e                fld;
    logic                  in_range;
    logic                  wr_go;
    pwm_cfg_t [NUM_CH-1:0] shadow_q;

    assign idx      = bus_waddr[ADDR_W-1:1];
    assign fld      = field_e'(bus_waddr[0]);
    assign in_range = 32'(bus_waddr) < 32'(SPAN);
    assign wr_go    = bus_sel && bus_wr && in_range;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
        end else if (wr_go) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (idx == IDX_W'(c)) begin
                    if (fld == FLD_HIGH) shadow_q[c].hi  <= bus_wdata;
                    else                 shadow_q[c].per <= bus_wdata;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (in_range && idx == IDX_W'(c)) begin
                bus_rdata = (fld == FLD_PERIOD) ? shadow_q[c].per : shadow_q[c].hi;
            end
        end
    end

    assign shadow_o = shadow_q;

    AST_OOR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && !in_range) |=> $stable(shadow_q)); // R2
    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!in_range) |-> (bus_rdata == '0)); // R2
    AST_IDLE_BUS_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!bus_sel) |=> $stable(shadow_q)); // R1

endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan
    import pwm_quad_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pwm_cfg_t shadow_i,
    output logic     pwm_o
);

    pwm_cfg_t act_q;
    word_t    cnt_q;
    logic     wrap;

    assign wrap = period_end(act_q, cnt_q);

    // Load both shadow fields at a period end (every cycle when idle).
    always_ff @(posedge clk) begin
        if (rst) begin
            act_q <= '0;
            cnt_q <= '0;
        end else if (wrap) begin
            act_q <= shadow_i;
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + word_t'(1);
        end
    end

    assign pwm_o = out_level(act_q, cnt_q);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (act_q.per != '0) |-> (cnt_q < act_q.per)); // R4
    AST_FULL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (act_q.per != '0 && act_q.hi >= act_q.per) |-> pwm_o); // R5
    AST_MIDPERIOD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (act_q.per != '0 && cnt_q != act_q.per - word_t'(1)) |=> $stable(act_q)); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (act_q.per == '0) |-> (cnt_q == '0 && !pwm_o)); // R7
    AST_IDLE_PICKUP: assert property (@(posedge clk) disable iff (rst)
        (act_q.per == '0) |=> (act_q == $past(shadow_i))); // R7

endmodule

// File: rtl/pwm_quad_gen.sv
module pwm_quad_gen
    import pwm_quad_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_waddr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    pwm_cfg_t [NUM_CH-1:0] shadow_cfg;

    pwm_quad_regs #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) regs_i (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_waddr (bus_waddr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .shadow_o  (shadow_cfg)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
        pwm_quad_chan chan_i (
            .clk      (clk),
            .rst      (rst),
            .shadow_i (shadow_cfg[g]),
            .pwm_o    (pwm_out[g])
        );
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (pwm_out == '0)); // R3

endmodule

// File: tb/pwm_quad_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_quad_gen_tb_top;

    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_waddr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;

    int unsigned n_checks = 0;
    int unsigned n_fails  = 0;
    bit          done     = 1'b0;

    // Behavioural model state, taken from the requirements.
    logic [31:0] m_sh_hi [NCH];
    logic [31:0] m_sh_per[NCH];
    logic [31:0] m_hi    [NCH];
    logic [31:0] m_per   [NCH];
    logic [31:0] m_cnt   [NCH];

    always #2.5 clk = ~clk;

    pwm_quad_gen dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_waddr (bus_waddr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pwm_out   (pwm_out)
    );

    function automatic logic [3:0] exp_out();
        logic [3:0] v;
        for (int c = 0; c < NCH; c++)
            v[c] = (m_per[c] != 0) && (m_cnt[c] < m_hi[c]);
        return v;
    endfunction

    function automatic logic [31:0] exp_read(input logic [5:0] a);
        if (a >= 6'(2 * NCH)) return 32'h0;
        return a[0] ? m_sh_per[a[5:1]] : m_sh_hi[a[5:1]];
    endfunction

    task automatic model_step();
        if (rst) begin
            for (int c = 0; c < NCH; c++) begin
                m_sh_hi[c] = 0; m_sh_per[c] = 0;
                m_hi[c] = 0; m_per[c] = 0; m_cnt[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (m_per[c] == 0 || m_cnt[c] == m_per[c] - 1) begin
                    m_hi[c]  = m_sh_hi[c];
                    m_per[c] = m_sh_per[c];
                    m_cnt[c] = 0;
                end else begin
                    m_cnt[c] = m_cnt[c] + 1;
                end
            end
            if (bus_sel && bus_wr && bus_waddr < 6'(2 * NCH)) begin
                if (bus_waddr[0]) m_sh_per[bus_waddr[5:1]] = bus_wdata;
                else              m_sh_hi[bus_waddr[5:1]]  = bus_wdata;
            end
        end
    endtask

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock: model follows the edge, outputs compared mid-cycle.
    task automatic cycle(input string tag);
        @(posedge clk);
        model_step();
        @(negedge clk);
        check(pwm_out == exp_out(), tag, 32'(pwm_out), 32'(exp_out()));
        bus_sel = 1'b0;
        bus_wr  = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
        cycle(tag);
    endtask

    task automatic rd_check(input logic [5:0] a, input string tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_waddr = a;
        #1;
        check(bus_rdata == exp_read(a), tag, bus_rdata, exp_read(a));
        cycle(tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cycle(tag);
    endtask

    task automatic do_reset(input string tag);
        rst = 1'b1;
        idle(3, tag);
        rst = 1'b0;
        for (int a = 0; a < 2 * NCH; a++) rd_check(6'(a), tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h5EED_0042);
        for (int c = 0; c < NCH; c++) begin
            m_sh_hi[c] = 0; m_sh_per[c] = 0; m_hi[c] = 0; m_per[c] = 0; m_cnt[c] = 0;
        end
        @(negedge clk);

        // R3: reset state
        do_reset("R3 reset");

        // R1: every register holds a full word and reads it back
        for (int a = 0; a < 2 * NCH; a++) wr(6'(a), 32'hA500_0000 | 32'(a * 3 + 1), "R1 write");
        wr(6'd1, 32'hFFFF_FFFF, "R1 write");
        for (int a = 0; a < 2 * NCH; a++) rd_check(6'(a), "R1 readback");
        do_reset("R3 second reset");

        // R2: out-of-range accesses
        for (int a = 2 * NCH; a < 64; a += 5) wr(6'(a), $urandom, "R2 write");
        for (int a = 0; a < 64; a += 3) rd_check(6'(a), "R2 read");
        idle(5, "R2 outputs");

        // R4 R5 R9: four channels with distinct settings
        wr(6'd0, 32'd2, "R7 setup"); wr(6'd1, 32'd5, "R7 start");
        wr(6'd2, 32'd7, "R5 setup"); wr(6'd3, 32'd3, "R5 start");
        wr(6'd5, 32'd4, "R5 setup"); wr(6'd4, 32'd0, "R5 zero high");
        wr(6'd6, 32'd1, "R4 setup"); wr(6'd7, 32'd1, "R4 single cycle");
        idle(30, "R4 R5 R9 run");

        // R6: mid-period reconfiguration of channel 0
        idle(2, "R6 align");
        wr(6'd0, 32'd4, "R6 change"); idle(1, "R6 hold"); wr(6'd1, 32'd6, "R6 change");
        idle(20, "R6 run");

        // R8: stop channel 1, then R7 restart from idle
        wr(6'd3, 32'd0, "R8 stop"); wr(6'd2, 32'd0, "R8 stop");
        idle(10, "R8 stopped");
        wr(6'd2, 32'd2, "R7 restart"); wr(6'd3, 32'd3, "R7 restart");
        idle(10, "R7 run");

        // R7: zero period with nonzero high stays idle
        wr(6'd5, 32'd0, "R7 idle"); idle(6, "R7 idle"); wr(6'd4, 32'd3, "R7 idle");
        idle(10, "R7 idle hold");

        // Random traffic over all channels and the whole address space
        for (int i = 0; i < 4000; i++) begin
            int unsigned r;
            r = $urandom % 32;
            if (r < 3) begin
                wr(6'($urandom % 8), ($urandom % 5 == 0) ? 32'd0 : 32'($urandom % 12), "R4 R5 R6 R7 R8 R9 random");
            end else if (r == 3) begin
                wr(6'($urandom % 64), 32'($urandom % 12), "R2 R6 random");
            end else if (r == 4) begin
                rd_check(6'($urandom % 64), "R1 R2 random read");
            end else begin
                cycle("R4 R5 R6 R7 R8 R9 random");
            end
        end

        finish_run();
    end

endmodule